// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a SPI master peripheral that software drives through a small 32-bit register port. Software sets the character length, the bit order, the clock prescaler and the loopback option in a mode register. It then writes a word to the transmit register. The block shifts the low-order bits of that word out on MOSI while it clocks SCK. At the same time it captures MISO. When the character is complete, the received bits appear right-justified in the receive register.

Two sticky event flags report progress: receive-data-ready and transmit-slot-free. Software clears each flag by writing a 1 to its bit. A mask register selects which flags drive the interrupt line. The buffering is a single word. A transmit write that arrives while a character is in flight is dropped, so software waits for the transmit-slot-free event before it writes again.

The register port has no back-pressure. Every write is accepted in the cycle it is presented. Read data is a combinational function of the address.

Top module: `spim_ctrl`

## Requirements
- R1: After reset the mode, mask, command and receive registers read 0, the event register reads 0x100 (transmit-slot-free set), and SCK, MOSI and the interrupt are low.
- R2: The length code in mode bits 23:20 selects the character length. Code 0 gives 32 bits, codes 1 to 3 give 4 bits, and a code n from 4 to 15 gives n+1 bits.
- R3: SCK idles low. With prescaler P in mode bits 19:16, each SCK half period lasts 2*(P+1) clocks. The first rising edge comes 2*(P+1) clocks after the clock edge that accepts the transmit write. The character ends 4*(P+1)*L clocks after that edge, where L is the character length.
- R4: With mode bit 26 set, bit L-1 of the transmit word is sent first. With bit 26 clear, bit 0 is sent first. Only the low L bits are sent. MOSI changes only on falling SCK edges (or at the start of a character) and is low when idle.
- R5: MISO is sampled on each rising SCK edge. The received character is right-justified in the receive register with the upper bits zero. The first received bit lands in bit L-1 when MSB-first is selected, and in bit 0 when LSB-first is selected.
- R6: With mode bit 30 set, MOSI is looped back internally to the receiver and the MISO pin is ignored. The receive register then equals the low L bits of the transmit word.
- R7: Event bit 9 (receive-data-ready) and event bit 8 (transmit-slot-free) are both set in the cycle a character completes. Writing 1 to an event bit clears it. Writing 0 leaves it unchanged. A completion in the same cycle as a clear wins.
- R8: The interrupt output is high exactly when an event bit is set and the mask register bit at the same position (9 or 8) is set.
- R9: A write to the transmit register starts a character only when mode bit 24 (enable) and mode bit 25 (master) are both set and no character is in flight. In any other case the write is ignored: no SCK activity, no events, and the receive register keeps its value.
- R10: Clearing the enable bit during a character aborts it. SCK and MOSI return low, no event is raised, and the receive register keeps its value.
- R11: Command register bit 22 is stored and reads back. No other command bit is stored, and the command register has no effect on transfers.
- R12: Register word addresses are 0 mode, 1 event, 2 mask, 3 command, 4 transmit and 5 receive. Transmit and unused addresses read 0. Only the defined mode bits (30, 26:16) are stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_irq | output | 1 | Masked event interrupt |

## Verification
The bench builds the block with its default parameters: a 32-bit word, a 4-bit length code and a 4-bit prescaler. Within that configuration it runs prescaler values 0 to 3, which keep even a 32-bit character to a few hundred clocks. This lets a single run cover every boundary length (4, 8, 12, 16, 32) in both bit orders and in loopback. It also covers the one-clock timing of the completion event and an abort partway through a long character.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 3;
  localparam int CODE_W = 4;
  localparam int PRE_W  = 4;
  localparam int LEN_W  = $clog2(WORD_W) + 1;

  // bit positions decoded by software
  localparam int MODE_LOOP_BIT   = 30;
  localparam int MODE_MSB_BIT    = 26;
  localparam int MODE_MASTER_BIT = 25;
  localparam int MODE_EN_BIT     = 24;
  localparam int MODE_LEN_LSB    = 20;
  localparam int MODE_PRE_LSB    = 16;
  localparam int EV_RDY_BIT      = 9;
  localparam int EV_FREE_BIT     = 8;
  localparam int CMD_LAST_BIT    = 22;

  localparam logic [ADDR_W-1:0] A_MODE  = 3'd0;
  localparam logic [ADDR_W-1:0] A_EVENT = 3'd1;
  localparam logic [ADDR_W-1:0] A_MASK  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMD   = 3'd3;
  localparam logic [ADDR_W-1:0] A_TX    = 3'd4;
  localparam logic [ADDR_W-1:0] A_RX    = 3'd5;

  typedef struct packed {
    logic              loopback;
    logic              msb_first;
    logic              master;
    logic              enable;
    logic [CODE_W-1:0] len_code;
    logic [PRE_W-1:0]  presc;
  } mode_t;

  // code 0 -> full word, 1..3 -> 4 bits, n -> n+1 bits
  function automatic logic [LEN_W-1:0] decode_len(input logic [CODE_W-1:0] code);
    if (code == '0) return LEN_W'(WORD_W);
    else if (code < CODE_W'(3)) return LEN_W'(4);
    else return LEN_W'(code) + LEN_W'(1);
  endfunction
endpackage

// File: rtl/spim_regfile.sv
module spim_regfile
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic              done_i,
  input  logic [WORD_W-1:0] rx_word_i,
  output mode_t             mode_o,
  output logic [WORD_W-1:0] rdata_o,
  output logic              irq_o
);
  mode_t             mode_q;
  logic              ev_rdy_q, ev_free_q;
  logic              msk_rdy_q, msk_free_q;
  logic              cmd_last_q;
  logic [WORD_W-1:0] rx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= '0;
      ev_rdy_q   <= 1'b0;
      ev_free_q  <= 1'b1;
      msk_rdy_q  <= 1'b0;
      msk_free_q <= 1'b0;
      cmd_last_q <= 1'b0;
      rx_q       <= '0;
    end else begin
      if (wr_i && addr_i == A_MODE) begin
        mode_q.loopback  <= wdata_i[MODE_LOOP_BIT];
        mode_q.msb_first <= wdata_i[MODE_MSB_BIT];
        mode_q.master    <= wdata_i[MODE_MASTER_BIT];
        mode_q.enable    <= wdata_i[MODE_EN_BIT];
        mode_q.len_code  <= wdata_i[MODE_LEN_LSB +: CODE_W];
        mode_q.presc     <= wdata_i[MODE_PRE_LSB +: PRE_W];
      end
      if (wr_i && addr_i == A_MASK) begin
        msk_rdy_q  <= wdata_i[EV_RDY_BIT];
        msk_free_q <= wdata_i[EV_FREE_BIT];
      end
      if (wr_i && addr_i == A_CMD) cmd_last_q <= wdata_i[CMD_LAST_BIT];
      if (done_i) begin
        ev_rdy_q  <= 1'b1;
        ev_free_q <= 1'b1;
        rx_q      <= rx_word_i;
      end else if (wr_i && addr_i == A_EVENT) begin
        if (wdata_i[EV_RDY_BIT])  ev_rdy_q  <= 1'b0;
        if (wdata_i[EV_FREE_BIT]) ev_free_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_MODE: begin
        rdata_o[MODE_LOOP_BIT]              = mode_q.loopback;
        rdata_o[MODE_MSB_BIT]               = mode_q.msb_first;
        rdata_o[MODE_MASTER_BIT]            = mode_q.master;
        rdata_o[MODE_EN_BIT]                = mode_q.enable;
        rdata_o[MODE_LEN_LSB +: CODE_W]     = mode_q.len_code;
        rdata_o[MODE_PRE_LSB +: PRE_W]      = mode_q.presc;
      end
      A_EVENT: begin
        rdata_o[EV_RDY_BIT]  = ev_rdy_q;
        rdata_o[EV_FREE_BIT] = ev_free_q;
      end
      A_MASK: begin
        rdata_o[EV_RDY_BIT]  = msk_rdy_q;
        rdata_o[EV_FREE_BIT] = msk_free_q;
      end
      A_CMD:   rdata_o[CMD_LAST_BIT] = cmd_last_q;
      A_RX:    rdata_o = rx_q;
      default: rdata_o = '0;
    endcase
  end

  assign mode_o = mode_q;
  assign irq_o  = (ev_rdy_q & msk_rdy_q) | (ev_free_q & msk_free_q);

  AST_EVENTS_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> (ev_rdy_q && ev_free_q)); // R7
  AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_i |=> $stable(rx_q)); // R10
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (msk_rdy_q || msk_free_q)); // R8
endmodule

// File: rtl/spim_clkgen.sv
module spim_clkgen #(
  parameter int PRE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [PRE_W-1:0] presc_i,
  input  logic             run_i,
  output logic             tick_o
);
  localparam int CNT_W = PRE_W + 2;

  logic [CNT_W-1:0] half_m1_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_m1_q <= '0;
      cnt_q     <= '0;
    end else if (load_i) begin
      half_m1_q <= {1'b0, presc_i, 1'b1};   // 2*(P+1)-1
      cnt_q     <= '0;
    end else if (run_i) begin
      cnt_q <= tick_o ? '0 : cnt_q + CNT_W'(1);
    end
  end

  assign tick_o = run_i && (cnt_q == half_m1_q);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (cnt_q <= half_m1_q)); // R3
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int WORD_W = 32,
  parameter int LEN_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [WORD_W-1:0] tx_word_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              msb_first_i,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              done_o,
  output logic [WORD_W-1:0] rx_word_o
);
  logic              busy_q, sck_q, mosi_q, msb_q;
  logic [WORD_W-1:0] sh_q, rx_q;
  logic [LEN_W-1:0]  left_q, len_q;
  logic [LEN_W-1:0]  pad_start;

  assign pad_start = LEN_W'(WORD_W) - len_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      mosi_q <= 1'b0;
      msb_q  <= 1'b0;
      sh_q   <= '0;
      rx_q   <= '0;
      left_q <= '0;
      len_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      sck_q  <= 1'b0;
      msb_q  <= msb_first_i;
      len_q  <= len_i;
      left_q <= len_i;
      rx_q   <= '0;
      sh_q   <= msb_first_i ? (tx_word_i << pad_start) : tx_word_i;
      mosi_q <= msb_first_i ? tx_word_i[len_i - LEN_W'(1)] : tx_word_i[0];
    end else if (busy_q) begin
      if (!en_i) begin
        busy_q <= 1'b0;
        sck_q  <= 1'b0;
        mosi_q <= 1'b0;
      end else if (tick_i) begin
        if (!sck_q) begin
          sck_q <= 1'b1;
          rx_q  <= msb_q ? {rx_q[WORD_W-2:0], miso_i} : {miso_i, rx_q[WORD_W-1:1]};
        end else begin
          sck_q <= 1'b0;
          if (left_q == LEN_W'(1)) begin
            busy_q <= 1'b0;
            mosi_q <= 1'b0;
          end else begin
            left_q <= left_q - LEN_W'(1);
            if (msb_q) begin
              sh_q   <= sh_q << 1;
              mosi_q <= sh_q[WORD_W-2];
            end else begin
              sh_q   <= sh_q >> 1;
              mosi_q <= sh_q[1];
            end
          end
        end
      end
    end
  end

  assign busy_o    = busy_q;
  assign sck_o     = sck_q;
  assign mosi_o    = mosi_q;
  assign done_o    = busy_q && en_i && tick_i && sck_q && (left_q == LEN_W'(1));
  assign rx_word_o = msb_q ? rx_q : (rx_q >> (LEN_W'(WORD_W) - len_q));

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> !sck_q); // R3
  AST_MOSI_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && sck_q) |-> $stable(mosi_q)); // R4
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !en_i && !start_i) |=> (!busy_q && !sck_q && !mosi_q)); // R10
  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_q); // R9
  AST_RX_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && len_q < LEN_W'(WORD_W)) |-> ((rx_word_o >> len_q) == '0)); // R5
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_irq
);
  mode_t             mode;
  logic              busy, tick, done, start, miso_int;
  logic [LEN_W-1:0]  len;
  logic [WORD_W-1:0] rx_word;

  assign len      = decode_len(mode.len_code);
  assign start    = reg_wr && (reg_addr == A_TX) && mode.enable && mode.master && !busy;
  assign miso_int = mode.loopback ? spi_mosi : spi_miso;

  spim_regfile u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (reg_wr),
    .addr_i   (reg_addr),
    .wdata_i  (reg_wdata),
    .done_i   (done),
    .rx_word_i(rx_word),
    .mode_o   (mode),
    .rdata_o  (reg_rdata),
    .irq_o    (spi_irq)
  );

  spim_clkgen #(.PRE_W(PRE_W)) u_clk (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (start),
    .presc_i(mode.presc),
    .run_i  (busy),
    .tick_o (tick)
  );

  spim_shifter #(.WORD_W(WORD_W), .LEN_W(LEN_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .tx_word_i  (reg_wdata),
    .len_i      (len),
    .msb_first_i(mode.msb_first),
    .en_i       (mode.enable),
    .tick_i     (tick),
    .miso_i     (miso_int),
    .busy_o     (busy),
    .sck_o      (spi_sck),
    .mosi_o     (spi_mosi),
    .done_o     (done),
    .rx_word_o  (rx_word)
  );

  AST_START_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(mode.enable && mode.master)); // R9
endmodule

// File: tb/spim_ctrl_tb_top.sv
module spim_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        spi_sck, spi_mosi, spi_irq;
  logic        spi_miso = 1'b0;

  always #10 clk = ~clk;

  spim_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_irq(spi_irq)
  );

  int total = 0;
  int bad = 0;
  bit cmp_on = 0;
  bit finished = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_mode, m_mask, m_cmd, m_rx, m_tx, m_acc;
  bit m_rdy, m_free, m_busy, m_msb;
  int m_t, m_H, m_L;

  function automatic int len_of(input logic [3:0] c);
    if (c == 0) return 32;
    if (c < 3) return 4;
    return int'(c) + 1;
  endfunction

  function automatic bit m_bit(input int j);
    return m_msb ? m_tx[m_L-1-j] : m_tx[j];
  endfunction

  always @(posedge clk) begin
    bit old_en, old_ms, old_busy, old_loop, done, v;
    int j;
    if (!rst_n) begin
      m_mode = 0; m_mask = 0; m_cmd = 0; m_rx = 0; m_tx = 0; m_acc = 0;
      m_rdy = 0; m_free = 1; m_busy = 0; m_msb = 0; m_t = 0; m_H = 2; m_L = 32;
    end else begin
      old_en = m_mode[24]; old_ms = m_mode[25]; old_busy = m_busy;
      old_loop = m_mode[30]; done = 0;
      if (m_busy) begin
        if (!old_en) m_busy = 0;
        else begin
          m_t++;
          if (m_t % (2*m_H) == m_H) begin
            j = m_t / (2*m_H);
            v = old_loop ? m_bit(j) : spi_miso;
            if (m_msb) m_acc[m_L-1-j] = v; else m_acc[j] = v;
          end
          if (m_t == 2*m_H*m_L) begin m_busy = 0; done = 1; m_rx = m_acc; end
        end
      end
      if (done) begin m_rdy = 1; m_free = 1; end
      else if (reg_wr && reg_addr == 1) begin
        if (reg_wdata[9]) m_rdy = 0;
        if (reg_wdata[8]) m_free = 0;
      end
      if (reg_wr && reg_addr == 4 && old_en && old_ms && !old_busy) begin
        m_busy = 1; m_t = 0; m_tx = reg_wdata; m_msb = m_mode[26];
        m_L = len_of(m_mode[23:20]); m_H = 2 * (int'(m_mode[19:16]) + 1); m_acc = 0;
      end
      if (reg_wr && reg_addr == 0) m_mode = reg_wdata & 32'h47FF_0000;
      if (reg_wr && reg_addr == 2) m_mask = reg_wdata & 32'h0000_0300;
      if (reg_wr && reg_addr == 3) m_cmd  = reg_wdata & 32'h0040_0000;
    end
  end

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_mode;
      3'd1: return {22'd0, m_rdy, m_free, 8'd0};
      3'd2: return m_mask;
      3'd3: return m_cmd;
      3'd5: return m_rx;
      default: return 32'd0;
    endcase
  endfunction

  // per-cycle comparison away from the edge
  always @(posedge clk) begin
    #5;
    if (rst_n && cmp_on) begin
      chk("R3", "sck", {31'd0, spi_sck}, {31'd0, m_busy && ((m_t / m_H) % 2 == 1)});
      chk("R4", "mosi", {31'd0, spi_mosi}, {31'd0, m_busy ? m_bit(m_t / (2*m_H)) : 1'b0});
      chk("R8", "irq", {31'd0, spi_irq},
          {31'd0, (m_rdy & m_mask[9]) | (m_free & m_mask[8])});
      chk("R12", "rdata", reg_rdata, m_read(reg_addr));
    end
  end

  // ---------------- slave responder ----------------
  logic [31:0] s_word = '0;
  int s_idx = 0;
  bit s_prev = 0;
  always @(posedge clk) begin
    #8;
    if (s_prev && !spi_sck) s_idx++;
    s_prev = spi_sck;
    spi_miso = s_word[s_idx % 32];
  end

  function automatic logic [31:0] exp_rx(input logic [31:0] sw, input int L, input bit msb);
    logic [31:0] r = 0;
    for (int j = 0; j < L; j++) begin
      if (msb) r[L-1-j] = sw[j]; else r[j] = sw[j];
    end
    return r;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string req, input string what);
    @(negedge clk); reg_addr = a;
    @(posedge clk); #5;
    chk(req, what, reg_rdata, exp);
  endtask

  task automatic run_xfer(input logic [31:0] tx, input logic [31:0] sw, input int L, input int H);
    s_word = sw; s_idx = 0;
    wr(4, tx);
    repeat (2*H*L + 2) @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1;
    cmp_on = 1;
    // R1 reset state
    rd_chk(0, 32'h0, "R1", "mode after reset");
    rd_chk(1, 32'h100, "R1", "event after reset");
    rd_chk(2, 32'h0, "R1", "mask after reset");
    rd_chk(5, 32'h0, "R1", "rx after reset");
    chk("R1", "sck/mosi/irq after reset", {29'd0, spi_sck, spi_mosi, spi_irq}, 32'd0);

    // R9 write while disabled is ignored
    run_xfer(32'h55, 32'hFFFF_FFFF, 8, 2);
    repeat (20) @(posedge clk); #5;
    chk("R9", "sck while disabled", {31'd0, spi_sck}, 32'd0);
    rd_chk(1, 32'h100, "R9", "events untouched when disabled");
    rd_chk(5, 32'h0, "R9", "rx untouched when disabled");

    // R5 R7 R8: 8-bit MSB-first, prescaler 0
    wr(0, 32'h0770_0000);
    wr(2, 32'h200);
    wr(1, 32'h300);
    rd_chk(1, 32'h0, "R7", "events cleared by writing ones");
    run_xfer(32'h1234_56A5, 32'h0000_00A6, 8, 2);
    rd_chk(5, exp_rx(32'hA6, 8, 1), "R5", "msb-first receive 8 bits");
    rd_chk(1, 32'h300, "R7", "both events after completion");
    chk("R8", "irq with ready masked in", {31'd0, spi_irq}, 32'd1);
    wr(1, 32'h200);
    rd_chk(1, 32'h100, "R7", "clear ready only");
    chk("R8", "irq after ready cleared", {31'd0, spi_irq}, 32'd0);

    // R4 R5: 32-bit LSB-first, prescaler 1
    wr(0, 32'h0301_0000);
    run_xfer(32'hDEAD_BEEF, 32'h0F0F_1234, 32, 4);
    rd_chk(5, 32'h0F0F_1234, "R5", "lsb-first receive 32 bits");

    // R6 loopback, 12 bits, prescaler 2
    wr(0, 32'h47B2_0000);
    run_xfer(32'hFFFF_0ABC, 32'h5555_5555, 12, 6);
    rd_chk(5, 32'h0000_0ABC, "R6", "loopback returns low 12 tx bits");

    // R2 R3 exact completion timing, code 1 -> 4 bits, prescaler 1
    wr(1, 32'h300);
    wr(0, 32'h0311_0000);
    s_word = 32'h9; s_idx = 0;
    wr(4, 32'h6);
    reg_addr = 1;
    repeat (31) @(posedge clk); #5;
    chk("R3", "no event one clock before end", reg_rdata, 32'h0);
    @(posedge clk); #5;
    chk("R2", "4-bit character ends at 32 clocks", reg_rdata, 32'h300);
    rd_chk(5, 32'h9, "R2", "code 1 gives 4 bits");

    // R2 code 15 -> 16 bits, MSB-first
    wr(0, 32'h07F0_0000);
    run_xfer(32'h0001_BEEF, 32'h0000_C001, 16, 2);
    rd_chk(5, exp_rx(32'hC001, 16, 1), "R2", "code 15 gives 16 bits");

    // R10 abort mid-character
    wr(1, 32'h300);
    wr(0, 32'h0703_0000);
    s_word = 32'hFFFF_FFFF; s_idx = 0;
    wr(4, 32'h1234_5678);
    repeat (40) @(posedge clk);
    wr(0, 32'h0603_0000);
    repeat (2) @(posedge clk); #5;
    chk("R10", "sck low after abort", {31'd0, spi_sck}, 32'd0);
    chk("R10", "mosi low after abort", {31'd0, spi_mosi}, 32'd0);
    repeat (600) @(posedge clk);
    rd_chk(1, 32'h0, "R10", "no event after abort");
    rd_chk(5, exp_rx(32'hC001, 16, 1), "R10", "rx kept after abort");

    // R9 transmit write while busy is dropped
    wr(0, 32'h0770_0000);
    s_word = 32'h5A; s_idx = 0;
    wr(4, 32'h81);
    repeat (5) @(posedge clk);
    wr(4, 32'hFF);
    repeat (40) @(posedge clk);
    rd_chk(5, exp_rx(32'h5A, 8, 1), "R9", "busy write ignored");

    // R11 command register
    wr(3, 32'hFFFF_FFFF);
    rd_chk(3, 32'h0040_0000, "R11", "only last bit stored");
    run_xfer(32'h3C, 32'h96, 8, 2);
    rd_chk(5, exp_rx(32'h96, 8, 1), "R11", "transfer unaffected by command");

    // R12 map
    rd_chk(4, 32'h0, "R12", "tx reads zero");
    rd_chk(6, 32'h0, "R12", "unused address reads zero");
    wr(0, 32'hFFFF_FFFF);
    rd_chk(0, 32'h47FF_0000, "R12", "mode stored bits");
    wr(0, 32'h0);
    repeat (4) @(posedge clk);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule